// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles conditional branches while the branch instruction sits in the decode stage of a five-stage pipeline. It holds the fetch address register and the fetch/decode pipeline register. Every cycle it looks at the instruction held in decode, together with the two register values read for it. It decides whether the branch is taken and computes where it goes. Fetch always carries on at the next sequential word, so the block follows a static predict-not-taken policy.

When a branch turns out taken, the block raises a PC-select and a flush in the same cycle. On the next clock edge it loads the target into the fetch address and clears the instruction that was fetched behind the branch to the all-zero no-op. A taken branch therefore costs exactly one fetch slot, and a not-taken branch costs nothing. Forwarding into decode, delay slots and dynamic prediction are left to other blocks.

Top module: `id_branch_unit`

## Requirements
- R1: While reset is held, and at the first sampling point after it, the fetch address equals RESET_PC (default 0), the decode instruction is all zeros, and pc_sel and flush are low.
- R2: With no taken branch in decode, each clock edge advances the fetch address by 4 and loads the fetched word into decode, with id_pc_plus4 set to that word's address plus 4.
- R3: Opcode 6'h04 in bits 31:26 of the decode instruction is the equal-branch: it is taken exactly when id_rs_val equals id_rt_val.
- R4: Opcode 6'h05 in bits 31:26 is the not-equal-branch: it is taken exactly when id_rs_val differs from id_rt_val.
- R5: Any other opcode, including the all-zero no-op, is never taken, whatever the operand values.
- R6: br_target equals id_pc_plus4 plus the sign-extended 16-bit field in bits 15:0 multiplied by 4, for positive, negative and extreme offsets (16'h7FFF, 16'h8000).
- R7: In the cycle a taken branch sits in decode, pc_sel and flush are both high. On the next edge the fetch address becomes br_target and the decode instruction becomes all zeros. A branch fetched directly behind a taken branch is flushed and never redirects.
- R8: A not-taken branch raises neither pc_sel nor flush. The instruction fetched after it enters decode unchanged, and fetch continues sequentially.
- R9: After a taken branch, the word at the target reaches decode on the second edge after the branch was in decode, while the fetch address moves on to target plus 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| if_instr | input | INSTR_W | Instruction word returned for the current fetch address |
| id_rs_val | input | DATA_W | First register value read for the decode instruction |
| id_rt_val | input | DATA_W | Second register value read for the decode instruction |
| if_pc | output | ADDR_W | Current fetch address |
| id_instr | output | INSTR_W | Instruction held in the fetch/decode register |
| id_pc_plus4 | output | ADDR_W | Sequential successor address of the decode instruction |
| pc_sel | output | 1 | High when the next fetch address is the branch target |
| br_target | output | ADDR_W | Computed branch destination |
| flush | output | 1 | High when the fetched instruction must be replaced by a no-op |

## Verification
pc_sel, flush and br_target depend only on the decode register and the operand inputs. They are due in the same cycle that the branch occupies decode, and the bench samples them at the falling edge of that cycle. The fetch address and the decode register pass through one flop each, so their redirect and flush effects are checked one rising edge after the decision. The target word's arrival in decode is checked at the second edge. Each scenario counts its edges from the release of reset: a branch placed at address 8 reaches decode after three edges.

// File: rtl/idbr_pkg.sv
// Package: shared encodings for the decode-stage branch resolver.
// Assumes opcode in the top six bits and a 16-bit offset in the low bits.
package idbr_pkg;
    localparam int OPC_W = 6;
    localparam int OFF_W = 16;
    localparam logic [OPC_W-1:0] OPC_BR_EQ = 6'h04;
    localparam logic [OPC_W-1:0] OPC_BR_NE = 6'h05;

    typedef enum logic [1:0] {
        COND_NONE = 2'd0,
        COND_EQ   = 2'd1,
        COND_NE   = 2'd2
    } br_cond_e;

    // Map an opcode onto the condition it tests.
    function automatic br_cond_e decode_cond(input logic [OPC_W-1:0] opc);
        case (opc)
            OPC_BR_EQ: decode_cond = COND_EQ;
            OPC_BR_NE: decode_cond = COND_NE;
            default:   decode_cond = COND_NONE;
        endcase
    endfunction
endpackage

// File: rtl/branch_cond.sv
// Module: branch_cond
// Decides whether the decode-stage instruction is a taken branch.
// Assumes operands are final (no forwarding into decode).
module branch_cond
    import idbr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OPC_W-1:0]     opcode,
    input  logic [DATA_W-1:0]    op_a,
    input  logic [DATA_W-1:0]    op_b,
    output logic                 taken
);
    br_cond_e cond;
    logic     same;

    // Equality compare and condition selection.
    always_comb begin
        cond = decode_cond(opcode);
        same = (op_a == op_b);
        case (cond)
            COND_EQ: taken = same;
            COND_NE: taken = !same;
            default: taken = 1'b0;
        endcase
    end

    // R3: equal-branch never taken on differing operands
    assert_eq_differ_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_BR_EQ && op_a != op_b) |-> !taken);
    // R4: not-equal-branch never taken on matching operands
    assert_ne_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_BR_NE && op_a == op_b) |-> !taken);
    // R5: other opcodes never taken
    assert_nonbranch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode != OPC_BR_EQ && opcode != OPC_BR_NE) |-> !taken);
endmodule

// File: rtl/branch_addr.sv
// Module: branch_addr
// Computes the branch destination from the successor address and the offset.
// Assumes ADDR_W exceeds OFF_W + 2 and word offsets (scaled by 4).
module branch_addr
    import idbr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc_plus4,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_ext;

    // Sign-extend, scale to bytes and add.
    always_comb begin
        off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
        target  = pc_plus4 + (off_ext << 2);
    end
endmodule

// File: rtl/fetch_regs.sv
// Module: fetch_regs
// Holds the fetch address and the fetch/decode register; applies redirect
// and flush on the same edge. Assumes no stall input.
module fetch_regs #(
    parameter int          ADDR_W   = 32,
    parameter int          INSTR_W  = 32,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               redirect,
    input  logic [ADDR_W-1:0]  target,
    input  logic [INSTR_W-1:0] fetched,
    output logic [ADDR_W-1:0]  pc,
    output logic [INSTR_W-1:0] dec_instr,
    output logic [ADDR_W-1:0]  dec_pc4
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    logic [ADDR_W-1:0] seq_pc;

    // Sequential successor of the current fetch address.
    always_comb seq_pc = pc + STEP;

    // Fetch address: target on redirect, else sequential.
    always_ff @(posedge clk) begin
        if (!rst_n)        pc <= ADDR_W'(RESET_PC);
        else if (redirect) pc <= target;
        else               pc <= seq_pc;
    end

    // Fetch/decode register: cleared to no-op on flush.
    always_ff @(posedge clk) begin
        if (!rst_n || redirect) begin
            dec_instr <= '0;
            dec_pc4   <= '0;
        end else begin
            dec_instr <= fetched;
            dec_pc4   <= seq_pc;
        end
    end

    // R2: sequential advance when not redirected
    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect |=> pc == $past(pc) + STEP);
    // R7: redirect loads the target
    assert_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> pc == $past(target));
    // R7: flushed slot becomes a no-op
    assert_flush_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> dec_instr == '0);
endmodule

// File: rtl/id_branch_unit.sv
// Module: id_branch_unit
// Decode-stage branch resolution with predict-not-taken fetch and a single
// flushed slot per taken branch. Assumes register values arrive final.
module id_branch_unit
    import idbr_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          DATA_W   = 32,
    parameter int          INSTR_W  = 32,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] if_instr,
    input  logic [DATA_W-1:0]  id_rs_val,
    input  logic [DATA_W-1:0]  id_rt_val,
    output logic [ADDR_W-1:0]  if_pc,
    output logic [INSTR_W-1:0] id_instr,
    output logic [ADDR_W-1:0]  id_pc_plus4,
    output logic               pc_sel,
    output logic [ADDR_W-1:0]  br_target,
    output logic               flush
);
    localparam int OPC_LSB = INSTR_W - OPC_W;

    logic taken;

    branch_cond #(.DATA_W(DATA_W)) u_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (id_instr[INSTR_W-1:OPC_LSB]),
        .op_a   (id_rs_val),
        .op_b   (id_rt_val),
        .taken  (taken)
    );

    branch_addr #(.ADDR_W(ADDR_W)) u_addr (
        .pc_plus4 (id_pc_plus4),
        .offset   (id_instr[OFF_W-1:0]),
        .target   (br_target)
    );

    fetch_regs #(
        .ADDR_W   (ADDR_W),
        .INSTR_W  (INSTR_W),
        .RESET_PC (RESET_PC)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .redirect  (taken),
        .target    (br_target),
        .fetched   (if_instr),
        .pc        (if_pc),
        .dec_instr (id_instr),
        .dec_pc4   (id_pc_plus4)
    );

    // Redirect select and flush both follow the decision.
    always_comb begin
        pc_sel = taken;
        flush  = taken;
    end

    // R7: a flushed slot never redirects on the following cycle
    assert_no_double_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !pc_sel);
endmodule

// File: tb/id_branch_unit_test.sv
`timescale 1ns/1ps
module id_branch_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] if_instr;
    logic [31:0] id_rs_val = '0;
    logic [31:0] id_rt_val = '0;
    logic [31:0] if_pc, id_instr, id_pc_plus4, br_target;
    logic        pc_sel, flush;

    int checks = 0;
    int errors = 0;
    logic [31:0] mem [0:63];

    always #4 clk = ~clk;

    assign if_instr = mem[if_pc[7:2]];

    id_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .if_instr(if_instr),
        .id_rs_val(id_rs_val), .id_rt_val(id_rt_val),
        .if_pc(if_pc), .id_instr(id_instr), .id_pc_plus4(id_pc_plus4),
        .pc_sel(pc_sel), .br_target(br_target), .flush(flush)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic go();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return mem[a[7:2]];
    endfunction

    task automatic fill();
        for (int i = 0; i < 64; i++) mem[i] = 32'h2000_0000 | 32'(i);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        go();
        go();
        rst_n = 1'b1;
    endtask

    // R1: reset state
    task automatic t_reset();
        fill();
        @(negedge clk);
        rst_n = 1'b0;
        go();
        go();
        check("R1 pc", if_pc, 32'h0);
        check("R1 instr", id_instr, 32'h0);
        check("R1 flush", {31'b0, flush}, 32'h0);
        check("R1 pc_sel", {31'b0, pc_sel}, 32'h0);
        rst_n = 1'b1;
    endtask

    // R2: sequential fetch
    task automatic t_seq();
        fill();
        do_reset();
        go();
        check("R2 pc", if_pc, 32'd4);
        check("R2 instr", id_instr, mem[0]);
        check("R2 pc4", id_pc_plus4, 32'd4);
        go();
        check("R2 pc", if_pc, 32'd8);
        check("R2 instr", id_instr, mem[1]);
        check("R2 pc4", id_pc_plus4, 32'd8);
    endtask

    // Branch at address 8; decision checked when it is in decode.
    task automatic t_branch(input string req, input logic [5:0] op,
                            input logic [31:0] a, input logic [31:0] b,
                            input logic [15:0] off, input bit exp_t);
        logic [31:0] tgt;
        tgt = 32'd12 + ({{16{off[15]}}, off} << 2);
        fill();
        mem[2] = {op, 5'd1, 5'd2, off};
        id_rs_val = a;
        id_rt_val = b;
        do_reset();
        go();
        go();
        go();
        check({req, " flush"}, {31'b0, flush}, {31'b0, exp_t});
        check({req, " pc_sel"}, {31'b0, pc_sel}, {31'b0, exp_t});
        check({req, " R6 target"}, br_target, tgt);
        go();
        check({req, " next pc"}, if_pc, exp_t ? tgt : 32'd16);
        check({req, " slot"}, id_instr, exp_t ? 32'h0 : mem[3]);
        go();
        if (exp_t) begin
            check({req, " R9 target word"}, id_instr, word_at(tgt));
            check({req, " R9 pc"}, if_pc, tgt + 32'd4);
        end else begin
            check({req, " R8 pc"}, if_pc, 32'd20);
        end
    endtask

    // R7: branch directly behind a taken branch is flushed
    task automatic t_back2back();
        fill();
        mem[2] = {6'h04, 5'd1, 5'd2, 16'd5};
        mem[3] = {6'h04, 5'd1, 5'd2, 16'd1};
        id_rs_val = 32'h55;
        id_rt_val = 32'h55;
        do_reset();
        go();
        go();
        go();
        check("R7 first flush", {31'b0, flush}, 32'h1);
        go();
        check("R7 second branch flushed", id_instr, 32'h0);
        check("R7 no second redirect", {31'b0, pc_sel}, 32'h0);
        check("R7 pc", if_pc, 32'd32);
        go();
        check("R7 pc after", if_pc, 32'd36);
        check("R9 word", id_instr, mem[8]);
    endtask

    initial begin
        fill();
        t_reset();
        t_seq();
        t_branch("R3 eq taken",      6'h04, 32'h1234, 32'h1234, 16'd5,    1'b1);
        t_branch("R3 R8 eq not",     6'h04, 32'h1234, 32'h1235, 16'd5,    1'b0);
        t_branch("R4 ne taken",      6'h05, 32'h0,    32'h8000_0000, 16'hFFFD, 1'b1);
        t_branch("R4 R8 ne not",     6'h05, 32'hABCD, 32'hABCD, 16'd7,    1'b0);
        t_branch("R5 other eq",      6'h08, 32'h9,    32'h9,    16'd5,    1'b0);
        t_branch("R5 noop ops",      6'h00, 32'h1,    32'h2,    16'd5,    1'b0);
        t_branch("R6 max fwd",       6'h04, 32'h7,    32'h7,    16'h7FFF, 1'b1);
        t_branch("R6 max back",      6'h04, 32'h7,    32'h7,    16'h8000, 1'b1);
        t_back2back();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule